// File: doc/BRIEF.md
# Packet-Boundary Graceful Reset Sequencer

This block sequences the reset of a streaming transmit engine's output stage without ever cutting a packet short on the link. It accepts two kinds of reset request. A bus-level request is honoured at once, because the link beneath it is resetting too and a truncated packet does no harm there. A logic-level request comes from the engine's own control while the link stays up, so it is deferred until the output stage has handed off the final beat of whatever packet it is holding.

The sequencer watches the output stage's valid, ready and last signals. While a logic request is deferred it raises a waiting flag. The surrounding logic folds the inverse of that flag into the valid that feeds the output stage, so no fresh beat is loaded while the sequencer waits. The reset pulse it drives has a fixed, parameterized length. When the pulse ends and no request remains, a done flag returns high. The reset pulse is brought out as an output so that downstream logic can stretch or delay it further.

All state changes on the rising clock edge. `rst_ni` is a synchronous, active-low power-on clear.

Top module: `grst_ctrl`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the following cycle shows `done_o` high and both `rst_o` and `waiting_o` low.
- R2: If `bus_rst_i` is high at a clock edge, `rst_o` is high in the next cycle and `waiting_o` and `done_o` are low. This holds in every state, including while waiting.
- R3: A logic request (`logic_rst_i` high) seen in the idle state moves the block straight to the active state on the next cycle if either of these holds in that cycle: `out_valid_i` is low, or `out_ready_i` and `out_last_i` are both high. The waiting state is skipped.
- R4: A logic request seen in the idle state while `out_valid_i` is high and the last beat is not being accepted raises `waiting_o` on the next cycle. `rst_o` stays low.
- R5: While waiting, the block stays waiting as long as `out_valid_i` is high and `out_ready_i`&`out_last_i` is low. It enters the active state on the cycle after `out_ready_i` and `out_last_i` are both high, or after `out_valid_i` drops.
- R6: In every cycle after reset, exactly one of `done_o` (idle), `waiting_o` (wait) and `rst_o` (active) is high.
- R7: Once the active state is entered and no request is present, `rst_o` stays high for exactly `RST_CYCLES` cycles. `done_o` rises in the cycle after the last of them.
- R8: `done_o` is low in every cycle in which `waiting_o` or `rst_o` is high, and it returns high only directly after an active cycle.
- R9: A logic request lasting a single cycle is enough. Once waiting has begun, it persists until the packet ends, with no need to hold the request.
- R10: A bus request arriving while the pulse is already running restarts the count. `rst_o` then stays high for `RST_CYCLES` cycles counted from the last cycle of the bus request.
- R11: While `logic_rst_i` stays high during the active state, `rst_o` stays high beyond `RST_CYCLES`. It falls on the cycle after the request drops, provided the count has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low power-on clear |
| bus_rst_i | input | 1 | Immediate reset request (link resetting) |
| logic_rst_i | input | 1 | Deferred reset request (engine only) |
| out_valid_i | input | 1 | Output stage holds a valid beat |
| out_ready_i | input | 1 | Link accepts the output beat |
| out_last_i | input | 1 | Output beat is the last of its packet |
| rst_o | output | 1 | Generated reset for the output stage |
| waiting_o | output | 1 | Deferring a logic reset; gate new beats |
| done_o | output | 1 | Reset sequence complete, block idle |

## Verification
The three outputs encode the state directly, so a wrong state shows up at the ports in the very next cycle. The effect would be a waiting flag where a pulse was due, a pulse that cuts a packet still in flight, or a done flag raised too early. A wrong count can hide inside a single pulse, but it shows when `done_o` rises: the rise comes too early or too late relative to the last request. The bench therefore measures the pulse width after each kind of entry. It also runs a cycle-by-cycle model against random traffic and random requests.

// File: rtl/grst_pkg.sv
package grst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'b001,
    ST_WAIT   = 3'b010,
    ST_ACTIVE = 3'b100
  } grst_state_e;
endpackage

// File: rtl/grst_cycle_timer.sv
module grst_cycle_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  // saturates at LAST; cleared whenever the pulse is not (re)running
  always_ff @(posedge clk_i) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/grst_seq_fsm.sv
module grst_seq_fsm
  import grst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        logic_req_i,
  input  logic        beat_valid_i,
  input  logic        last_taken_i,
  input  logic        timer_expired_i,
  output grst_state_e state_o
);
  grst_state_e state_q, state_d;
  logic        boundary;

  // safe point: nothing in flight, or the closing beat leaves this cycle
  assign boundary = !beat_valid_i || last_taken_i;

  always_comb begin
    state_d = state_q;
    if (bus_req_i) begin
      state_d = ST_ACTIVE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (logic_req_i) state_d = boundary ? ST_ACTIVE : ST_WAIT;
        ST_WAIT:   if (boundary) state_d = ST_ACTIVE;
        ST_ACTIVE: if (timer_expired_i && !logic_req_i) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/grst_ctrl.sv
module grst_ctrl
  import grst_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic logic_rst_i,
  input  logic out_valid_i,
  input  logic out_ready_i,
  input  logic out_last_i,
  output logic rst_o,
  output logic waiting_o,
  output logic done_o
);
  grst_state_e state;
  logic        expired;
  logic        timer_clear;

  // restart on any bus request, hold at zero outside the active state
  assign timer_clear = bus_rst_i || (state != ST_ACTIVE);

  grst_cycle_timer #(
    .CYCLES (RST_CYCLES)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (timer_clear),
    .expired_o (expired)
  );

  grst_seq_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .bus_req_i       (bus_rst_i),
    .logic_req_i     (logic_rst_i),
    .beat_valid_i    (out_valid_i),
    .last_taken_i    (out_ready_i && out_last_i),
    .timer_expired_i (expired),
    .state_o         (state)
  );

  assign rst_o     = (state == ST_ACTIVE);
  assign waiting_o = (state == ST_WAIT);
  assign done_o    = (state == ST_IDLE);
endmodule

// File: rtl/grst_ctrl_chk.sv
module grst_ctrl_chk #(
  parameter int unsigned RST_CYCLES = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_rst_i,
  input logic logic_rst_i,
  input logic out_valid_i,
  input logic out_ready_i,
  input logic out_last_i,
  input logic rst_o,
  input logic waiting_o,
  input logic done_o
);
  int unsigned run_q;

  // consecutive active cycles since the last bus request
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                     run_q <= 0;
    else if (!rst_o || bus_rst_i)    run_q <= 0;
    else if (run_q < RST_CYCLES)     run_q <= run_q + 1;
  end

  p_bus_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> rst_o && !waiting_o && !done_o);

  p_skip_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && logic_rst_i && !bus_rst_i && (!out_valid_i || (out_ready_i && out_last_i)) |=> rst_o);

  p_defer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && logic_rst_i && !bus_rst_i && out_valid_i && !(out_ready_i && out_last_i)
      |=> waiting_o && !rst_o);

  p_wait_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o && !bus_rst_i && out_valid_i && !(out_ready_i && out_last_i) |=> waiting_o);

  p_wait_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o && (!out_valid_i || (out_ready_i && out_last_i)) |=> rst_o);

  p_one_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rst_o, waiting_o, done_o}) == 1);

  p_done_after_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rst_o));

  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> run_q == RST_CYCLES);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o && logic_rst_i |=> rst_o);
endmodule

bind grst_ctrl grst_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/grst_ctrl_tb_top.sv
module grst_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_rst = 1'b0, logic_rst = 1'b0;
  logic valid = 1'b0, ready = 1'b0, last = 1'b0;
  logic rst_o, waiting_o, done_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  // reference model: 0 idle, 1 wait, 2 active
  int m_st = 0;
  int m_ran = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grst_ctrl #(.RST_CYCLES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst), .logic_rst_i(logic_rst),
    .out_valid_i(valid), .out_ready_i(ready), .out_last_i(last),
    .rst_o(rst_o), .waiting_o(waiting_o), .done_o(done_o));

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st <= 0; m_ran <= 0;
    end else if (bus_rst) begin
      m_st <= 2; m_ran <= 1;
    end else if (m_st == 0) begin
      if (logic_rst) begin
        if (!valid || (ready && last)) begin m_st <= 2; m_ran <= 1; end
        else m_st <= 1;
      end
    end else if (m_st == 1) begin
      if (!valid || (ready && last)) begin m_st <= 2; m_ran <= 1; end
    end else begin
      if (m_ran >= N && !logic_rst) m_st <= 0;
      else if (m_ran < N) m_ran <= m_ran + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_ni) begin
      chk({rst_o, waiting_o, done_o} == {m_st == 2, m_st == 1, m_st == 0}, cur_req,
          "model {rst,wait,done}", int'({rst_o, waiting_o, done_o}),
          int'({m_st == 2, m_st == 1, m_st == 0}));
      chk($countones({rst_o, waiting_o, done_o}) == 1, "R6", "one state flag",
          $countones({rst_o, waiting_o, done_o}), 1);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // called at a negedge where rst_o is high; returns width and leaves at the first low cycle
  task automatic pulse_width(output int w);
    w = 0;
    while (rst_o && w < 1000) begin w++; step(); end
  endtask

  task automatic settle();
    valid = 1'b0; ready = 1'b0; last = 1'b0; logic_rst = 1'b0; bus_rst = 1'b0;
    while (!done_o) step();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    step(3);
    cur_req = "R1";
    chk(done_o && !rst_o && !waiting_o, "R1", "reset state {rst,wait,done}",
        int'({rst_o, waiting_o, done_o}), 1);
    rst_ni = 1'b1;
    model_on = 1'b1;
    step(2);

    // R3/R7: single-cycle logic pulse, nothing in flight
    cur_req = "R3";
    logic_rst = 1'b1; step();
    logic_rst = 1'b0;
    chk(rst_o, "R3", "rst_o after idle logic request", rst_o, 1);
    cur_req = "R7";
    pulse_width(w);
    chk(w == N, "R7", "pulse width", w, N);
    chk(done_o, "R7", "done_o after pulse", done_o, 1);
    settle();

    // R4/R5/R9: request during a packet
    cur_req = "R4";
    valid = 1'b1;
    logic_rst = 1'b1; step();
    logic_rst = 1'b0;
    chk(waiting_o && !rst_o, "R4", "waiting_o during packet", waiting_o, 1);
    chk(!done_o, "R8", "done_o while waiting", done_o, 0);
    cur_req = "R9";
    step(5);
    chk(waiting_o, "R9", "waiting held after pulse", waiting_o, 1);
    cur_req = "R5";
    ready = 1'b1; step(2);
    chk(waiting_o, "R5", "waiting with ready but no last", waiting_o, 1);
    last = 1'b1; step();
    valid = 1'b0; ready = 1'b0; last = 1'b0;
    chk(rst_o, "R5", "rst_o after last beat taken", rst_o, 1);
    pulse_width(w);
    chk(w == N, "R7", "pulse width after wait", w, N);
    settle();

    // R5: valid dropping releases the wait
    cur_req = "R5";
    valid = 1'b1; logic_rst = 1'b1; step();
    logic_rst = 1'b0; step(2);
    valid = 1'b0; step();
    chk(rst_o, "R5", "rst_o after valid drop", rst_o, 1);
    settle();

    // R3: last beat accepted in the request cycle skips the wait
    cur_req = "R3";
    valid = 1'b1; ready = 1'b1; last = 1'b1; logic_rst = 1'b1; step();
    logic_rst = 1'b0; valid = 1'b0; ready = 1'b0; last = 1'b0;
    chk(rst_o && !waiting_o, "R3", "direct active on accepted last", rst_o, 1);
    settle();

    // R2/R10: bus request while waiting
    cur_req = "R2";
    valid = 1'b1; logic_rst = 1'b1; step();
    logic_rst = 1'b0; step(2);
    bus_rst = 1'b1; step();
    bus_rst = 1'b0;
    chk(rst_o && !waiting_o && !done_o, "R2", "bus reset overrides wait", rst_o, 1);
    cur_req = "R10";
    pulse_width(w);
    chk(w == N, "R10", "pulse width after bus reset", w, N);
    settle();

    // R2: bus reset in idle with traffic present
    cur_req = "R2";
    valid = 1'b1; bus_rst = 1'b1; step();
    bus_rst = 1'b0;
    chk(rst_o, "R2", "bus reset ignores traffic", rst_o, 1);
    // R10: restart mid-pulse
    cur_req = "R10";
    step(4);
    bus_rst = 1'b1; step();
    bus_rst = 1'b0;
    pulse_width(w);
    chk(w == N, "R10", "pulse width after restart", w, N);
    settle();

    // R11: logic request held past the count
    cur_req = "R11";
    logic_rst = 1'b1; step(N + 6);
    chk(rst_o, "R11", "rst_o held by request", rst_o, 1);
    logic_rst = 1'b0; step();
    chk(done_o && !rst_o, "R11", "done_o after release", done_o, 1);
    settle();

    // random traffic against the model
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      valid = ($urandom_range(0, 3) != 0);
      ready = $urandom_range(0, 1);
      last  = ($urandom_range(0, 3) == 0);
      logic_rst = ($urandom_range(0, 40) == 0);
      bus_rst   = ($urandom_range(0, 150) == 0);
      step();
    end
    settle();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule